// File: doc/BRIEF.md
# Remote DMA Host Port Engine

This block moves data between a host data port and the local packet memory of a network controller. The host programs a starting byte address and a byte count, one byte per register write, and then reads or writes the data port repeatedly. Each port access moves one, two or four bytes in a single clock cycle. The engine advances the pointer, wraps it inside the receive ring and counts the remaining bytes down. When the count runs out, it raises a sticky completion flag that the interrupt logic clears.

The packet memory sits outside the block and answers reads combinationally. Only two windows of the memory exist: a small station area at the bottom and a large packet area higher up. Accesses that start outside both windows never reach the memory. A read there returns all ones, and a write there is lost. The pointer and the count still move in both cases.

The engine keeps a two-state controller. `ST_EMPTY` means the count is zero and `ST_RUN` means bytes remain. Three transitions leave or enter these states:
- `EMPTY->RUN` happens when a count byte load makes the count non-zero.
- `RUN->EMPTY` happens on the access that uses up the count, or when a count load makes it zero.
- `EMPTY->EMPTY` happens on a read with a zero count. That read still goes through and sets the flag.

Top module: `rdma_host_engine`

## Requirements
- R1: After reset the pointer and count are 0, the completion flag is low and no memory strobe is active.
- R2: The step size is 4 bytes when `host_long` is 1. Otherwise it is 2 bytes when `word_mode` is 1 and 1 byte when `word_mode` is 0. An access with count above the step lowers the count by the step.
- R3: Each performed access adds the step to the pointer, using the pointer before alignment. If the sum equals `ring_stop_addr`, the pointer becomes `ring_start_addr`.
- R4: An access with count at or below the step leaves the count at 0 and sets the completion flag in the next cycle.
- R5: A host write while the count is 0 does nothing: no memory write, no pointer or flag change. A host read while the count is 0 still reads, advances the pointer and sets the flag.
- R6: The memory is accessed only when the aligned address is below 32, or at least 16384 and below 49152. Outside these ranges, reads return all ones in the step width and writes raise no memory strobe.
- R7: For 2- and 4-byte steps, address bit 0 is cleared before the access. Data is little-endian: the byte at the lowest address is in bits 7:0, and bits above the step width of `host_rdata` are 0.
- R8: `cmd_go` with `cmd_remote` high while the count is 0 sets the completion flag. With `cmd_remote` low it has no effect on the flag.
- R9: `cfg_wr_sel` chooses the byte to load: 0 is pointer bits 7:0, 1 is pointer high byte, 2 is count bits 7:0, 3 is count high byte. A host access in the same cycle takes priority over the load.
- R10: The completion flag stays set until `done_clr`. If setting and clearing fall in the same cycle, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Byte load strobe for pointer/count |
| cfg_wr_sel | input | 2 | Byte load target (see R9) |
| cfg_wr_data | input | 8 | Byte load value |
| ring_start_addr | input | 16 | Ring first byte address |
| ring_stop_addr | input | 16 | Ring end address (exclusive) |
| word_mode | input | 1 | 1: 2-byte port steps, 0: 1-byte steps |
| cmd_go | input | 1 | Command issue pulse |
| cmd_remote | input | 1 | Command selects a remote read or write |
| done_clr | input | 1 | Clears the completion flag |
| host_rd | input | 1 | Host data port read |
| host_wr | input | 1 | Host data port write |
| host_long | input | 1 | Access is 4 bytes wide |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the read cycle |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address (aligned) |
| mem_nbytes | output | 3 | Bytes in this memory access |
| mem_wdata | output | 32 | Memory write data, little-endian |
| mem_rdata | input | 32 | Memory read data, little-endian, combinational |
| cur_addr | output | 16 | Current pointer |
| cur_count | output | 16 | Remaining byte count |
| dma_done | output | 1 | Completion flag |

## Verification
The hardest case to reach is an access that is both the wrapping one and the final one. In that cycle the pointer must jump back to the ring start, the count must clamp to zero and the flag must rise, all at once. The stimulus also has to hit an odd pointer that lands exactly on the stop address only because the step is added before alignment. Directed sequences place the pointer two bytes below the stop address with a matching count. The random phase draws small rings and short counts, so wraps and count exhaustion overlap often, and mixes in window-edge addresses and writes at zero count.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_RUN   = 1'b1
    } rdma_state_e;

    typedef enum logic [1:0] {
        SEL_PTR_LO = 2'd0,
        SEL_PTR_HI = 2'd1,
        SEL_CNT_LO = 2'd2,
        SEL_CNT_HI = 2'd3
    } rdma_sel_e;

    function automatic logic [2:0] step_of(input logic wide, input logic lng);
        if (lng)       return 3'd4;
        else if (wide) return 3'd2;
        else           return 3'd1;
    endfunction
endpackage

// File: rtl/rdma_ptr.sv
module rdma_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [7:0]    ld_byte,
    input  logic          adv_en,
    input  logic [2:0]    step,
    input  logic [AW-1:0] ring_start,
    input  logic [AW-1:0] ring_stop,
    output logic [AW-1:0] ptr
);
    localparam int HIW = AW - 8;

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] sum;
    logic [AW-1:0] ptr_d;

    always_comb begin
        sum   = ptr_q + AW'(step);
        ptr_d = ptr_q;
        if (adv_en) begin
            ptr_d = (sum == ring_stop) ? ring_start : sum;
        end else if (ld_lo) begin
            ptr_d[7:0] = ld_byte;
        end else if (ld_hi) begin
            ptr_d[AW-1:8] = ld_byte[HIW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/rdma_cnt.sv
module rdma_cnt
    import rdma_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [7:0]    ld_byte,
    input  logic          dec_en,
    input  logic [2:0]    step,
    input  logic          zero_cmd,
    input  logic          done_clr,
    output logic [CW-1:0] count,
    output rdma_state_e   state,
    output logic          done
);
    localparam int HIW = CW - 8;

    rdma_state_e   st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d, cnt_ld;
    logic          done_q, done_d;
    logic          last_acc;

    always_comb begin
        cnt_ld = cnt_q;
        if (ld_lo)      cnt_ld[7:0]    = ld_byte;
        else if (ld_hi) cnt_ld[CW-1:8] = ld_byte[HIW-1:0];
        last_acc = dec_en && (cnt_q <= CW'(step));
    end

    // next-state process
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: begin
                if (!dec_en && (ld_lo || ld_hi) && (cnt_ld != '0)) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (last_acc) st_d = ST_EMPTY;
                else if (!dec_en && (ld_lo || ld_hi) && (cnt_ld == '0)) st_d = ST_EMPTY;
            end
            default: st_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // output process: count and completion flag
    always_comb begin
        cnt_d  = cnt_q;
        done_d = done_q && !done_clr;
        unique case (st_q)
            ST_EMPTY: begin
                if (dec_en) begin
                    cnt_d  = '0;
                    done_d = 1'b1;
                end else if (ld_lo || ld_hi) begin
                    cnt_d = cnt_ld;
                end
                if (zero_cmd) done_d = 1'b1;
            end
            ST_RUN: begin
                if (last_acc) begin
                    cnt_d  = '0;
                    done_d = 1'b1;
                end else if (dec_en) begin
                    cnt_d = cnt_q - CW'(step);
                end else if (ld_lo || ld_hi) begin
                    cnt_d = cnt_ld;
                end
            end
            default: cnt_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            done_q <= done_d;
        end
    end

    assign count = cnt_q;
    assign state = st_q;
    assign done  = done_q;
endmodule

// File: rtl/rdma_port.sv
module rdma_port #(
    parameter int AW            = 16,
    parameter int DW            = 32,
    parameter int LOW_WIN_END   = 32,
    parameter int HIGH_WIN_BASE = 16384,
    parameter int HIGH_WIN_END  = 49152
) (
    input  logic [AW-1:0] ptr,
    input  logic [2:0]    step,
    input  logic          rd_go,
    input  logic          wr_go,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] host_rdata,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [2:0]    mem_nbytes,
    output logic [DW-1:0] mem_wdata
);
    localparam int NLANE = DW / 8;

    logic [AW-1:0] eff;
    logic [31:0]   eff32;
    logic          in_win;
    logic [DW-1:0] raw;

    always_comb begin
        eff      = ptr;
        if (step != 3'd1) eff[0] = 1'b0;
        eff32    = 32'(eff);
        in_win   = (eff32 < 32'(LOW_WIN_END)) ||
                   ((eff32 >= 32'(HIGH_WIN_BASE)) && (eff32 < 32'(HIGH_WIN_END)));
        raw      = in_win ? mem_rdata : '1;
    end

    genvar g;
    generate
        for (g = 0; g < NLANE; g++) begin : g_lane
            assign host_rdata[g*8 +: 8] = (g < int'(step)) ? raw[g*8 +: 8] : 8'h00;
            assign mem_wdata[g*8 +: 8]  = (g < int'(step)) ? host_wdata[g*8 +: 8] : 8'h00;
        end
    endgenerate

    assign mem_rd_en  = rd_go && in_win;
    assign mem_wr_en  = wr_go && in_win;
    assign mem_addr   = eff;
    assign mem_nbytes = step;
endmodule

// File: rtl/rdma_host_engine.sv
module rdma_host_engine
    import rdma_pkg::*;
#(
    parameter int AW            = 16,
    parameter int DW            = 32,
    parameter int LOW_WIN_END   = 32,
    parameter int HIGH_WIN_BASE = 16384,
    parameter int HIGH_WIN_END  = 49152
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_en,
    input  logic [1:0]    cfg_wr_sel,
    input  logic [7:0]    cfg_wr_data,
    input  logic [AW-1:0] ring_start_addr,
    input  logic [AW-1:0] ring_stop_addr,
    input  logic          word_mode,
    input  logic          cmd_go,
    input  logic          cmd_remote,
    input  logic          done_clr,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic          host_long,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [2:0]    mem_nbytes,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_count,
    output logic          dma_done
);
    logic [2:0]  step;
    logic        cnt_zero;
    logic        wr_go;
    logic        acc_go;
    rdma_state_e run_st;

    assign step     = step_of(word_mode, host_long);
    assign cnt_zero = (run_st == ST_EMPTY);
    assign wr_go    = host_wr && !cnt_zero;
    assign acc_go   = host_rd || wr_go;

    rdma_ptr #(.AW(AW)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_lo      (cfg_wr_en && cfg_wr_sel == SEL_PTR_LO),
        .ld_hi      (cfg_wr_en && cfg_wr_sel == SEL_PTR_HI),
        .ld_byte    (cfg_wr_data),
        .adv_en     (acc_go),
        .step       (step),
        .ring_start (ring_start_addr),
        .ring_stop  (ring_stop_addr),
        .ptr        (cur_addr)
    );

    rdma_cnt #(.CW(AW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_lo    (cfg_wr_en && cfg_wr_sel == SEL_CNT_LO),
        .ld_hi    (cfg_wr_en && cfg_wr_sel == SEL_CNT_HI),
        .ld_byte  (cfg_wr_data),
        .dec_en   (acc_go),
        .step     (step),
        .zero_cmd (cmd_go && cmd_remote && cnt_zero),
        .done_clr (done_clr),
        .count    (cur_count),
        .state    (run_st),
        .done     (dma_done)
    );

    rdma_port #(
        .AW            (AW),
        .DW            (DW),
        .LOW_WIN_END   (LOW_WIN_END),
        .HIGH_WIN_BASE (HIGH_WIN_BASE),
        .HIGH_WIN_END  (HIGH_WIN_END)
    ) u_port (
        .ptr        (cur_addr),
        .step       (step),
        .rd_go      (host_rd),
        .wr_go      (wr_go),
        .host_wdata (host_wdata),
        .mem_rdata  (mem_rdata),
        .host_rdata (host_rdata),
        .mem_rd_en  (mem_rd_en),
        .mem_wr_en  (mem_wr_en),
        .mem_addr   (mem_addr),
        .mem_nbytes (mem_nbytes),
        .mem_wdata  (mem_wdata)
    );
endmodule

// File: rtl/rdma_host_engine_chk.sv
module rdma_host_engine_chk
    import rdma_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        word_mode,
    input logic        host_long,
    input logic        host_rd,
    input logic        host_wr,
    input logic        cmd_go,
    input logic        cmd_remote,
    input logic        done_clr,
    input logic [15:0] ring_start_addr,
    input logic [15:0] ring_stop_addr,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [15:0] mem_addr,
    input logic [2:0]  mem_nbytes,
    input logic [15:0] cur_addr,
    input logic [15:0] cur_count,
    input logic        dma_done,
    input rdma_state_e run_st
);
    logic [2:0]  chk_step;
    logic [15:0] exp_dec;
    logic        acc;

    assign chk_step = host_long ? 3'd4 : (word_mode ? 3'd2 : 3'd1);
    assign exp_dec  = cur_count - {13'b0, chk_step};
    assign acc      = host_rd || (host_wr && cur_count != '0);

    a_r1_state_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        (run_st == ST_RUN) == (cur_count != '0));

    a_r2_count_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cur_count > {13'b0, chk_step}) |=> cur_count == $past(exp_dec));

    a_r3_never_parks_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ring_start_addr != ring_stop_addr) |=> cur_addr != $past(ring_stop_addr));

    a_r4_final_access_done: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cur_count <= {13'b0, chk_step}) |=> (dma_done && cur_count == '0));

    a_r5_zero_count_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rd && cur_count == '0) |-> !mem_wr_en);

    a_r6_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |->
        (mem_addr < 16'd32 || (mem_addr >= 16'd16384 && mem_addr < 16'd49152)));

    a_r7_aligned_wide: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd_en || mem_wr_en) && mem_nbytes != 3'd1) |-> !mem_addr[0]);

    a_r8_zero_length_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && cmd_remote && cur_count == '0) |=> dma_done);

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && !done_clr) |=> dma_done);
endmodule

bind rdma_host_engine rdma_host_engine_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .word_mode       (word_mode),
    .host_long       (host_long),
    .host_rd         (host_rd),
    .host_wr         (host_wr),
    .cmd_go          (cmd_go),
    .cmd_remote      (cmd_remote),
    .done_clr        (done_clr),
    .ring_start_addr (ring_start_addr),
    .ring_stop_addr  (ring_stop_addr),
    .mem_rd_en       (mem_rd_en),
    .mem_wr_en       (mem_wr_en),
    .mem_addr        (mem_addr),
    .mem_nbytes      (mem_nbytes),
    .cur_addr        (cur_addr),
    .cur_count       (cur_count),
    .dma_done        (dma_done),
    .run_st          (run_st)
);

// File: tb/rdma_host_engine_tb_top.sv
module rdma_host_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic [15:0] ring_start_addr = 16'h4000;
    logic [15:0] ring_stop_addr = 16'h8000;
    logic        word_mode = 1'b0;
    logic        cmd_go = 1'b0;
    logic        cmd_remote = 1'b0;
    logic        done_clr = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_long = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_addr;
    logic [2:0]  mem_nbytes;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [15:0] cur_addr, cur_count;
    logic        dma_done;

    always #2 clk = ~clk;

    rdma_host_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .ring_start_addr(ring_start_addr),
        .ring_stop_addr(ring_stop_addr), .word_mode(word_mode), .cmd_go(cmd_go),
        .cmd_remote(cmd_remote), .done_clr(done_clr), .host_rd(host_rd),
        .host_wr(host_wr), .host_long(host_long), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_nbytes(mem_nbytes), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cur_addr(cur_addr), .cur_count(cur_count),
        .dma_done(dma_done)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] bmem [int];
    logic [15:0] m_addr = '0;
    logic [15:0] m_cnt = '0;
    bit m_done = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int stepf(bit lg);
        return lg ? 4 : (word_mode ? 2 : 1);
    endfunction

    function automatic bit inwin(logic [15:0] a);
        return (a < 16'd32) || (a >= 16'd16384 && a < 16'd49152);
    endfunction

    function automatic logic [7:0] rbyte(logic [15:0] a);
        if (bmem.exists(int'(a))) return bmem[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic check_state(input string req);
        chk(req, "cur_addr", {16'b0, cur_addr}, {16'b0, m_addr});
        chk(req, "cur_count", {16'b0, cur_count}, {16'b0, m_cnt});
        chk(req, "dma_done", {31'b0, dma_done}, {31'b0, m_done});
    endtask

    task automatic cfgw(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
        case (sel)
            2'd0: m_addr[7:0]  = d;
            2'd1: m_addr[15:8] = d;
            2'd2: m_cnt[7:0]   = d;
            default: m_cnt[15:8] = d;
        endcase
    endtask

    task automatic setup(input logic [15:0] a, input logic [15:0] c);
        cfgw(2'd0, a[7:0]); cfgw(2'd1, a[15:8]);
        cfgw(2'd2, c[7:0]); cfgw(2'd3, c[15:8]);
    endtask

    task automatic cmd(input bit remote);
        @(negedge clk);
        cmd_go = 1'b1; cmd_remote = remote;
        @(posedge clk); #1;
        cmd_go = 1'b0; cmd_remote = 1'b0;
        if (remote && m_cnt == 16'd0) m_done = 1'b1;
    endtask

    task automatic clr();
        @(negedge clk);
        done_clr = 1'b1;
        @(posedge clk); #1;
        done_clr = 1'b0;
        m_done = 1'b0;
    endtask

    task automatic acc(input string req, input bit wr, input bit lg, input logic [31:0] wd);
        int n;
        logic [15:0] eff;
        bit active, win;
        logic [31:0] exp_rd, mask;
        @(negedge clk);
        n = stepf(lg);
        eff = m_addr;
        if (n > 1) eff[0] = 1'b0;
        active = !wr || (m_cnt != 16'd0);
        win = inwin(eff);
        mask = (n == 4) ? 32'hFFFFFFFF : (n == 2 ? 32'h0000FFFF : 32'h000000FF);
        mem_rdata = {rbyte(eff + 16'd3), rbyte(eff + 16'd2), rbyte(eff + 16'd1), rbyte(eff)};
        exp_rd = (win ? mem_rdata : 32'hFFFFFFFF) & mask;
        host_rd = !wr; host_wr = wr; host_long = lg; host_wdata = wd;
        #1;
        if (!wr) chk(req, "host_rdata", host_rdata, exp_rd);
        chk(req, "mem_rd_en", {31'b0, mem_rd_en}, {31'b0, (!wr && win)});
        chk(req, "mem_wr_en", {31'b0, mem_wr_en}, {31'b0, (wr && active && win)});
        if (active && win) begin
            chk(req, "mem_addr", {16'b0, mem_addr}, {16'b0, eff});
            chk(req, "mem_nbytes", {29'b0, mem_nbytes}, 32'(n));
        end
        if (wr && active && win) begin
            chk(req, "mem_wdata", mem_wdata & mask, wd & mask);
            for (int i = 0; i < n; i++) bmem[int'(eff + 16'(i))] = wd[i*8 +: 8];
        end
        if (active) begin
            m_addr = m_addr + 16'(n);
            if (m_addr == ring_stop_addr) m_addr = ring_start_addr;
            if (m_cnt <= 16'(n)) begin m_cnt = 16'd0; m_done = 1'b1; end
            else m_cnt = m_cnt - 16'(n);
        end
        @(posedge clk); #1;
        host_rd = 1'b0; host_wr = 1'b0; host_long = 1'b0;
        check_state(req);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1", "cur_addr", {16'b0, cur_addr}, 32'h0);
        chk("R1", "cur_count", {16'b0, cur_count}, 32'h0);
        chk("R1", "dma_done", {31'b0, dma_done}, 32'h0);
        chk("R1", "mem_strobes", {30'b0, mem_rd_en, mem_wr_en}, 32'h0);

        // R8 zero-length remote command, and non-remote command
        cmd(1'b0); check_state("R8");
        cmd(1'b1); check_state("R8");
        clr(); check_state("R10");

        // R9 byte loads
        setup(16'h4010, 16'h0105); check_state("R9");

        // R2 and R4: word mode reads down to zero
        word_mode = 1'b1;
        setup(16'h4020, 16'd5);
        acc("R2", 1'b0, 1'b0, 0);
        acc("R2", 1'b0, 1'b0, 0);
        acc("R4", 1'b0, 1'b0, 0);
        // R10 done sticky over idle cycles, then cleared
        repeat (3) @(posedge clk);
        #1 check_state("R10");
        clr(); check_state("R10");

        // R3 wrap, coinciding with final access
        ring_start_addr = 16'h4000; ring_stop_addr = 16'h4100;
        setup(16'h40FE, 16'd2);
        acc("R3", 1'b0, 1'b0, 0);
        clr();
        // R3 odd pointer reaching stop through unaligned add
        word_mode = 1'b0;
        setup(16'h40FB, 16'd20);
        acc("R3", 1'b0, 1'b1, 0);
        acc("R3", 1'b0, 1'b0, 0);

        // R7 odd pointer word write and little-endian readback
        word_mode = 1'b1;
        setup(16'h4011, 16'd2);
        acc("R7", 1'b1, 1'b0, 32'hCAFE_BEEF);
        clr();
        word_mode = 1'b0;
        setup(16'h4010, 16'd2);
        acc("R7", 1'b0, 1'b0, 0);
        acc("R7", 1'b0, 1'b0, 0);
        clr();

        // R5 write at zero count is dropped, read at zero proceeds
        acc("R5", 1'b1, 1'b1, 32'h1234_5678);
        acc("R5", 1'b0, 1'b0, 0);
        clr();

        // R6 window edges
        ring_stop_addr = 16'hFFF0;
        setup(16'd31, 16'd100);
        acc("R6", 1'b0, 1'b0, 0);
        acc("R6", 1'b0, 1'b0, 0);
        acc("R6", 1'b1, 1'b0, 32'hA5);
        setup(16'd16383, 16'd100);
        acc("R6", 1'b0, 1'b0, 0);
        acc("R6", 1'b0, 1'b1, 0);
        setup(16'd49151, 16'd100);
        acc("R6", 1'b0, 1'b0, 0);
        acc("R6", 1'b1, 1'b1, 32'hDEAD_0001);
        acc("R6", 1'b0, 1'b1, 0);
        clr();

        // random phase
        for (int it = 0; it < 60; it++) begin
            logic [15:0] base;
            int pages;
            pages = 1 + int'($urandom_range(3));
            base = 16'h4000 + 16'($urandom_range(60)) * 16'h0100;
            ring_start_addr = base;
            ring_stop_addr = base + 16'(pages * 256);
            word_mode = $urandom_range(1) == 1;
            setup(ring_stop_addr - 16'($urandom_range(12)), 16'($urandom_range(24)));
            for (int k = 0; k < 12; k++) begin
                acc("R2", $urandom_range(2) == 0, $urandom_range(3) == 0, $urandom);
            end
            if ($urandom_range(1) == 1) clr();
        end

        finish_up();
    end
endmodule